// File: doc/BRIEF.md
# Multi-Sequencer Sample Collection FIFO

This block is the collection back end of a four-sequencer converter. Each sequencer owns a 16-entry sample FIFO, an enable bit, a 4-bit event-source selector and a raw interrupt flag. When a single-cycle timer pulse arrives, every sequencer that is enabled and whose selector holds the timer code (5) receives one sample and raises its raw interrupt flag. The sample comes from an internal generator, a 32-bit linear congruential state that advances once per generated sample. It can instead come from the `ext_sample` input port.

Software works through a simple register port. Reads are combinational and writes take effect at the clock edge. Reading a sequencer's data register removes the oldest sample. Reading its status word shows both FIFO pointers and the empty and full flags. Interrupt lines follow the raw flags gated by a mask, and a write-one-to-clear register acknowledges them. A read from an empty FIFO returns zero and sets a sticky underflow flag.

Global registers: 0x00 enable (bit n = sequencer n), 0x04 event selectors (nibble n), 0x08 raw flags (read only), 0x0C mask, 0x10 acknowledge (write 1 clears raw bit n; reads raw AND mask), 0x14 underflow (sticky, write 1 clears), 0x18 source select (bit 0: 1 = external port). Sequencer n occupies 0x40 + 0x20·n: +0x00 routing word, +0x04 control word, +0x08 data (pop), +0x0C status. Any other address reads zero and ignores writes.

Top module: `adcq_seq_fifo`

## Requirements
- R1: After reset every status word reads 0x100 and the enable, raw, mask, underflow and source registers read 0. All interrupt lines are low.
- R2: The status word holds the read pointer in bits 3:0, the write pointer in bits 7:4, EMPTY in bit 8 and FULL in bit 12. A push advances the write pointer modulo 16 and a pop advances the read pointer modulo 16.
- R3: A push that makes the pointers equal sets FULL. A push into a full FIFO is dropped and leaves the status word unchanged.
- R4: A data read from an empty FIFO returns 0, leaves the status word unchanged and sets underflow bit n at 0x14. Writing 1 to that bit clears it.
- R5: On a timer pulse, sequencer n pushes one sample and sets raw bit n when enable bit n is 1 and selector nibble n equals 5. The raw bit is set even if the push is dropped.
- R6: A timer pulse leaves a sequencer unchanged when its enable bit is 0 or its selector is not 5.
- R7: Interrupt line n is high exactly while raw bit n and mask bit n are both 1. Address 0x10 reads raw AND mask.
- R8: The generator state starts at 0. For each generated sample it becomes state·314159+1 (mod 2^32), and the sample is 0x200 plus bits 18:16 of the new state. Within one pulse, sequencers are served in ascending index.
- R9: Data reads return samples oldest first. EMPTY sets when the read pointer reaches the write pointer.
- R10: Writing 1 to bit n of 0x10 clears raw bit n. A qualifying pulse in the same cycle wins, and the bit stays set.
- R11: With bit 0 of 0x18 set, pushed samples take the value of `ext_sample` and the generator state does not advance.
- R12: A push and a pop to one FIFO in the same cycle are judged on the flags before the edge. When the FIFO is full, the pop happens and the push is dropped. When it is empty, the push happens and the pop underflows.
- R13: The routing word stores the written value AND 0x33333333. The control word stores all 32 bits. Both read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on a data register) |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| timer_pulse | input | 1 | Single-cycle timer trigger |
| ext_sample | input | DATA_W | Sample value used when the external source is selected |
| irq | output | NSEQ | Per-sequencer interrupt lines |

## Verification
The trigger is applied with mixed enable and selector settings: two sequencers qualify, one is disabled and one selects another source. This separates the enable test from the selector test and checks the ascending generator order across two sequencers. The FIFOs are filled past capacity and then drained, which exercises pointer wrap, a dropped push and oldest-first order. Reads are then made on an empty FIFO to show the zero result and the underflow flag. Coincident push and pop on a full FIFO and on an empty FIFO show whether flags are judged before the edge. An acknowledge that coincides with a trigger shows whether set wins. Switching to the external source and back shows whether the generator pauses.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
    // global register offsets
    localparam int REG_ENABLE = 'h00;
    localparam int REG_EVSEL  = 'h04;
    localparam int REG_RAW    = 'h08;
    localparam int REG_MASK   = 'h0C;
    localparam int REG_ACK    = 'h10;
    localparam int REG_UNDER  = 'h14;
    localparam int REG_SRC    = 'h18;
    // per-sequencer window
    localparam int SEQ_BASE      = 'h40;
    localparam int SEQ_STRIDE_LG = 5;
    localparam int SOFF_ROUTE    = 'h00;
    localparam int SOFF_CTL      = 'h04;
    localparam int SOFF_DATA     = 'h08;
    localparam int SOFF_STAT     = 'h0C;
    // status word layout
    localparam int ST_HEAD_LSB = 4;
    localparam int ST_EMPTY    = 8;
    localparam int ST_FULL     = 12;
    // event source and generator
    localparam int          EV_W        = 4;
    localparam logic [3:0]  EV_TIMER    = 4'd5;
    localparam logic [31:0] ROUTE_KEEP  = 32'h3333_3333;
    localparam logic [31:0] LCG_MUL     = 32'd314159;
    localparam logic [31:0] LCG_INC     = 32'd1;
    localparam int          SAMPLE_BASE = 'h200;
    localparam int          NOISE_LSB   = 16;
    localparam int          NOISE_W     = 3;
endpackage

// File: rtl/adcq_fifo.sv
module adcq_fifo
    import adcq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] front,
    output logic [31:0]       status,
    output logic              underflow
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q, head_n, tail_n;
    logic              empty_q, full_q, do_push, do_pop;

    always_comb begin
        do_push = push && !full_q;
        do_pop  = pop && !empty_q;
        head_n  = head_q + PTR_W'(do_push);
        tail_n  = tail_q + PTR_W'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
        end else begin
            head_q <= head_n;
            tail_q <= tail_n;
            if (do_push && !do_pop) begin
                empty_q <= 1'b0;
                full_q  <= (head_n == tail_n);
            end else if (do_pop && !do_push) begin
                full_q  <= 1'b0;
                empty_q <= (tail_n == head_n);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[head_q] <= push_data;
    end

    assign front     = empty_q ? '0 : mem[tail_q];
    assign underflow = pop && empty_q;

    always_comb begin
        status                          = '0;
        status[PTR_W-1:0]               = tail_q;
        status[ST_HEAD_LSB +: PTR_W]    = head_q;
        status[ST_EMPTY]                = empty_q;
        status[ST_FULL]                 = full_q;
    end
endmodule

// File: rtl/adcq_noise.sv
module adcq_noise
    import adcq_pkg::*;
#(
    parameter int NSEQ   = 4,
    parameter int DATA_W = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSEQ-1:0]             adv,
    output logic [NSEQ-1:0][DATA_W-1:0] gen
);
    logic [31:0]        st_q;
    logic [NSEQ:0][31:0] chain;

    assign chain[0] = st_q;

    for (genvar n = 0; n < NSEQ; n++) begin : g_step
        logic [31:0] stepped;
        assign stepped     = chain[n] * LCG_MUL + LCG_INC;
        assign chain[n+1]  = adv[n] ? stepped : chain[n];
        assign gen[n]      = DATA_W'(SAMPLE_BASE) + DATA_W'(stepped[NOISE_LSB +: NOISE_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= chain[NSEQ];
    end
endmodule

// File: rtl/adcq_seq_fifo.sv
module adcq_seq_fifo
    import adcq_pkg::*;
#(
    parameter int NSEQ   = 4,
    parameter int DEPTH  = 16,
    parameter int DATA_W = 10,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              timer_pulse,
    input  logic [DATA_W-1:0] ext_sample,
    output logic [NSEQ-1:0]   irq
);
    localparam int EVS_W = NSEQ * EV_W;

    logic [NSEQ-1:0]             en_q, raw_q, mask_q, under_q;
    logic [EVS_W-1:0]            evsel_q;
    logic                        src_ext_q;
    logic [NSEQ-1:0]             hit, adv, push_v, pop_v, underflow_v, seq_sel;
    logic [NSEQ-1:0][31:0]       stat_v, seq_rd, route_q, ctl_q;
    logic [NSEQ-1:0][DATA_W-1:0] front_v, gen_v, samp_v;
    logic                        wr_en, wr_ev, wr_mask, wr_ack, wr_under, wr_src;

    assign wr_en    = bus_wr && bus_addr == ADDR_W'(REG_ENABLE);
    assign wr_ev    = bus_wr && bus_addr == ADDR_W'(REG_EVSEL);
    assign wr_mask  = bus_wr && bus_addr == ADDR_W'(REG_MASK);
    assign wr_ack   = bus_wr && bus_addr == ADDR_W'(REG_ACK);
    assign wr_under = bus_wr && bus_addr == ADDR_W'(REG_UNDER);
    assign wr_src   = bus_wr && bus_addr == ADDR_W'(REG_SRC);

    adcq_noise #(.NSEQ(NSEQ), .DATA_W(DATA_W)) u_noise (
        .clk(clk), .rst_n(rst_n), .adv(adv), .gen(gen_v)
    );

    for (genvar n = 0; n < NSEQ; n++) begin : g_seq
        localparam logic [ADDR_W-1:0] WIN = ADDR_W'(SEQ_BASE + (n << SEQ_STRIDE_LG));
        logic [SEQ_STRIDE_LG-1:0] off;

        assign off        = bus_addr[SEQ_STRIDE_LG-1:0];
        assign seq_sel[n] = bus_addr[ADDR_W-1:SEQ_STRIDE_LG] == WIN[ADDR_W-1:SEQ_STRIDE_LG];
        assign hit[n]     = timer_pulse && en_q[n] && evsel_q[n*EV_W +: EV_W] == EV_TIMER;
        assign adv[n]     = hit[n] && !src_ext_q;
        assign push_v[n]  = hit[n];
        assign pop_v[n]   = bus_rd && seq_sel[n] && off == SEQ_STRIDE_LG'(SOFF_DATA);
        assign samp_v[n]  = src_ext_q ? ext_sample : gen_v[n];

        adcq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(push_v[n]), .push_data(samp_v[n]),
            .pop(pop_v[n]), .front(front_v[n]),
            .status(stat_v[n]), .underflow(underflow_v[n])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                route_q[n] <= '0;
                ctl_q[n]   <= '0;
            end else if (bus_wr && seq_sel[n]) begin
                if (off == SEQ_STRIDE_LG'(SOFF_ROUTE)) route_q[n] <= bus_wdata & ROUTE_KEEP;
                if (off == SEQ_STRIDE_LG'(SOFF_CTL))   ctl_q[n]   <= bus_wdata;
            end
        end

        always_comb begin
            seq_rd[n] = '0;
            if (seq_sel[n]) begin
                unique case (off)
                    SEQ_STRIDE_LG'(SOFF_ROUTE): seq_rd[n] = route_q[n];
                    SEQ_STRIDE_LG'(SOFF_CTL):   seq_rd[n] = ctl_q[n];
                    SEQ_STRIDE_LG'(SOFF_DATA):  seq_rd[n] = 32'(front_v[n]);
                    SEQ_STRIDE_LG'(SOFF_STAT):  seq_rd[n] = stat_v[n];
                    default:                    seq_rd[n] = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            evsel_q   <= '0;
            mask_q    <= '0;
            src_ext_q <= 1'b0;
            raw_q     <= '0;
            under_q   <= '0;
        end else begin
            if (wr_en)   en_q      <= bus_wdata[NSEQ-1:0];
            if (wr_ev)   evsel_q   <= bus_wdata[EVS_W-1:0];
            if (wr_mask) mask_q    <= bus_wdata[NSEQ-1:0];
            if (wr_src)  src_ext_q <= bus_wdata[0];
            raw_q   <= (raw_q & ~(wr_ack ? bus_wdata[NSEQ-1:0] : '0)) | hit;
            under_q <= (under_q & ~(wr_under ? bus_wdata[NSEQ-1:0] : '0)) | underflow_v;
        end
    end

    assign irq = raw_q & mask_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_ENABLE))     bus_rdata = 32'(en_q);
        else if (bus_addr == ADDR_W'(REG_EVSEL)) bus_rdata = 32'(evsel_q);
        else if (bus_addr == ADDR_W'(REG_RAW))   bus_rdata = 32'(raw_q);
        else if (bus_addr == ADDR_W'(REG_MASK))  bus_rdata = 32'(mask_q);
        else if (bus_addr == ADDR_W'(REG_ACK))   bus_rdata = 32'(raw_q & mask_q);
        else if (bus_addr == ADDR_W'(REG_UNDER)) bus_rdata = 32'(under_q);
        else if (bus_addr == ADDR_W'(REG_SRC))   bus_rdata = 32'(src_ext_q);
        else begin
            for (int n = 0; n < NSEQ; n++) bus_rdata = bus_rdata | seq_rd[n];
        end
    end
endmodule

// File: rtl/adcq_checker.sv
module adcq_checker
    import adcq_pkg::*;
#(
    parameter int NSEQ = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  timer_pulse,
    input logic [NSEQ-1:0]       en,
    input logic [NSEQ*EV_W-1:0]  evsel,
    input logic [NSEQ-1:0]       raw,
    input logic [NSEQ-1:0]       push,
    input logic [NSEQ-1:0]       pop,
    input logic [NSEQ-1:0]       under,
    input logic [NSEQ-1:0][31:0] stat
);
    for (genvar n = 0; n < NSEQ; n++) begin : g_chk
        // R5: a qualifying pulse leaves the raw flag set
        a_r5_trigger_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
            (timer_pulse && en[n] && evsel[n*EV_W +: EV_W] == EV_TIMER) |=> raw[n]);
        // R3: push into a full FIFO leaves the status untouched
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (push[n] && stat[n][ST_FULL] && !pop[n]) |=> $stable(stat[n]));
        // R4: pop from empty keeps pointers and latches underflow
        a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
            (pop[n] && stat[n][ST_EMPTY] && !push[n]) |=> ($stable(stat[n]) && under[n]));
        // R6: with no push or pop the status holds
        a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (!push[n] && !pop[n]) |=> $stable(stat[n]));
        // R2: EMPTY and FULL never together
        a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(stat[n][ST_EMPTY] && stat[n][ST_FULL]));
    end
endmodule

bind adcq_seq_fifo adcq_checker #(.NSEQ(NSEQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .timer_pulse(timer_pulse),
    .en(en_q), .evsel(evsel_q), .raw(raw_q),
    .push(push_v), .pop(pop_v), .under(under_q), .stat(stat_v)
);

// File: tb/adcq_seq_fifo_test.sv
module adcq_seq_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, timer_pulse = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  ext_sample = '0;
    logic [3:0]  irq;

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model state
    int unsigned m_noise = 0;
    bit [3:0]    m_en = 0, m_raw = 0, m_mask = 0, m_under = 0;
    bit [15:0]   m_ev = 0;
    bit          m_src = 0;
    int          m_q[4][$];
    int          m_hd[4] = '{0, 0, 0, 0};
    int          m_tl[4] = '{0, 0, 0, 0};
    int unsigned m_route[4] = '{0, 0, 0, 0};
    int unsigned m_ctl[4] = '{0, 0, 0, 0};

    adcq_seq_fifo uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .timer_pulse(timer_pulse), .ext_sample(ext_sample), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned exp_read(input int a);
        int n, off, sz;
        case (a)
            'h00: return m_en;
            'h04: return m_ev;
            'h08: return m_raw;
            'h0C: return m_mask;
            'h10: return m_raw & m_mask;
            'h14: return m_under;
            'h18: return m_src;
            default: ;
        endcase
        if (a >= 'h40 && a < 'hC0) begin
            n = (a - 'h40) >> 5;
            off = a & 31;
            sz = m_q[n].size();
            case (off)
                0: return m_route[n];
                4: return m_ctl[n];
                8: return (sz == 0) ? 0 : m_q[n][0];
                12: return ((sz == 16) ? 32'h1000 : 0) | ((sz == 0) ? 32'h100 : 0)
                           | (m_hd[n] << 4) | m_tl[n];
                default: return 0;
            endcase
        end
        return 0;
    endfunction

    // one bus cycle; entered just after a rising edge
    task automatic step(input bit wr, input bit rd, input int a, input int unsigned d,
                        input bit trig, input int ext, input string req);
        bit [3:0] hits, under_set, clr_raw, clr_under;
        int sz[4];
        int unsigned s;
        bus_wr = wr; bus_rd = rd; bus_addr = a[7:0]; bus_wdata = d;
        timer_pulse = trig; ext_sample = ext[9:0];
        @(negedge clk);
        if (rd) check(req, bus_rdata, exp_read(a));
        check("R7 irq", 32'(irq), 32'(m_raw & m_mask));
        @(posedge clk);
        for (int n = 0; n < 4; n++) begin
            sz[n] = m_q[n].size();
            hits[n] = trig && m_en[n] && m_ev[n*4 +: 4] == 4'd5;
        end
        under_set = 0;
        clr_raw   = (wr && a == 'h10) ? d[3:0] : 4'h0;
        clr_under = (wr && a == 'h14) ? d[3:0] : 4'h0;
        for (int n = 0; n < 4; n++) begin
            if (hits[n]) begin
                if (!m_src) begin
                    m_noise = m_noise * 314159 + 1;
                    s = 'h200 + ((m_noise >> 16) & 7);
                end else s = ext;
                if (sz[n] < 16) begin
                    m_q[n].push_back(s);
                    m_hd[n] = (m_hd[n] + 1) % 16;
                end
            end
            if (rd && a == 'h48 + n * 'h20) begin
                if (sz[n] == 0) under_set[n] = 1'b1;
                else begin
                    void'(m_q[n].pop_front());
                    m_tl[n] = (m_tl[n] + 1) % 16;
                end
            end
        end
        if (wr) begin
            case (a)
                'h00: m_en = d[3:0];
                'h04: m_ev = d[15:0];
                'h0C: m_mask = d[3:0];
                'h18: m_src = d[0];
                default: if (a >= 'h40 && a < 'hC0) begin
                    if ((a & 31) == 0) m_route[(a - 'h40) >> 5] = d & 32'h3333_3333;
                    if ((a & 31) == 4) m_ctl[(a - 'h40) >> 5] = d;
                end
            endcase
        end
        m_raw   = (m_raw & ~clr_raw) | hits;
        m_under = (m_under & ~clr_under) | under_set;
        #1;
        bus_wr = 0; bus_rd = 0; timer_pulse = 0;
    endtask

    task automatic rd(input int a, input string req);
        step(0, 1, a, 0, 0, 0, req);
    endtask

    task automatic wr(input int a, input int unsigned d, input string req);
        step(1, 0, a, d, 0, 0, req);
    endtask

    task automatic trig(input string req);
        step(0, 0, 0, 0, 1, 0, req);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int n = 0; n < 4; n++) rd('h4C + n * 'h20, "R1 status");
        rd('h00, "R1 enable");
        rd('h08, "R1 raw");
        rd('h14, "R1 underflow");
        rd('h18, "R1 source");
        // R5 / R6: seq0, seq2 qualify; seq1 disabled; seq3 wrong source
        wr('h00, 32'hD, "R5");
        wr('h04, 32'h3555, "R5");
        trig("R5");
        rd('h08, "R5 raw");
        rd('h6C, "R6 disabled seq");
        rd('hAC, "R6 other source seq");
        rd('h4C, "R2 status after push");
        rd('h8C, "R2 status after push");
        rd('h48, "R8 generated sample seq0");
        rd('h88, "R8 generated sample seq2");
        // R4 empty pop and sticky underflow
        rd('h48, "R4 empty read");
        rd('h4C, "R4 pointers held");
        rd('h14, "R4 underflow set");
        wr('h14, 32'h1, "R4");
        rd('h14, "R4 underflow cleared");
        // R3 fill past capacity, pointers wrap
        for (int i = 0; i < 18; i++) trig("R3");
        rd('h4C, "R3 full status");
        rd('h8C, "R3 full status");
        // R12 push and pop together on full
        step(0, 1, 'h48, 0, 1, 0, "R12 pop on full");
        rd('h4C, "R12 status after full push+pop");
        // R9 drain oldest first
        for (int i = 0; i < 16; i++) rd('h48, "R9 drain order");
        rd('h4C, "R9 empty after drain");
        // R12 push and pop together on empty
        step(0, 1, 'h48, 0, 1, 0, "R12 pop on empty");
        rd('h4C, "R12 status after empty push+pop");
        rd('h14, "R12 underflow");
        rd('h48, "R9 pushed sample");
        // R7 mask and acknowledge
        wr('h0C, 32'h1, "R7");
        rd('h10, "R7 masked read");
        wr('h10, 32'h1, "R10 clear");
        rd('h08, "R10 raw after clear");
        trig("R10");
        step(1, 0, 'h10, 32'h5, 1, 0, "R10 set wins");
        rd('h08, "R10 raw after clear with pulse");
        // R11 external source on seq3
        wr('h04, 32'h5555, "R11");
        wr('h18, 32'h1, "R11");
        step(0, 0, 0, 0, 1, 'h155, "R11");
        rd('hA8, "R11 external sample");
        wr('h18, 32'h0, "R11");
        trig("R11");
        rd('hA8, "R11 generator resumes");
        // R13 routing and control storage
        wr('h40, 32'hFFFF_FFFF, "R13");
        rd('h40, "R13 routing mask");
        wr('h64, 32'hDEAD_BEEF, "R13");
        rd('h64, "R13 control word");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule